// File: doc/BRIEF.md
# RV32I Instruction Decoder

This block is the purely combinational decode stage of a single-cycle RV32I core. It takes one 32-bit instruction word. From it, the block produces the two source register addresses, the destination register address and a 32-bit sign-extended immediate. It also produces the control word that steers the rest of the datapath: the ALU first and second operand routing, the memory read and write strobes, the register-file write strobe and the write-back source. The block holds no state and has no clock. A new instruction presented on the input is fully decoded in the same cycle.

Internally the opcode is first mapped onto one of ten instruction classes. These are NONE, REG, ALUI, LOAD, STORE, BRANCH, LUI, AUIPC, JAL and JALR. The class is the only thing the immediate unit and the control unit look at. Any opcode outside the nine supported ones maps to NONE. The block has no transitions between classes: the class follows the opcode in every cycle. CSR access, fences, environment calls, compressed encodings and traps are not decoded. They fall into NONE.

Top module: `rvdec_top`

## Requirements
- R1: A load (opcode 0000011) drives the memory read strobe to 1, the memory write strobe to 0, the register write strobe to 1, the write-back select to 1 (memory data), operand-1 select to 0 (rs1) and operand-2 select to 1 (immediate).
- R2: A store (opcode 0100011) drives the memory write strobe to 1, the memory read strobe to 0, the register write strobe to 0, the write-back select to 0, operand-1 select to 0 (base rs1) and operand-2 select to 1 (offset).
- R3: An immediate arithmetic instruction (opcode 0010011) drives operand-1 select to 0 and operand-2 select to 1, with both memory strobes at 0, the register write strobe at 1 and the write-back select at 0 (ALU result).
- R4: The immediate is formed per class and sign-extended from bit 31:
  - I-class (ALUI, LOAD, JALR): bits [31:20].
  - S-class: bits [31:25] over [11:7].
  - B-class: bit 31, bit 7, bits [30:25], bits [11:8], then a zero LSB.
  - U-class: bits [31:12] over twelve zeros.
  - J-class: bit 31, bits [19:12], bit 20, bits [30:21], then a zero LSB.
  - REG and NONE: zero.
- R5: JAL (opcode 1101111) drives operand-1 select to 1 (instruction address) and operand-2 select to 1, the register write strobe to 1, the write-back select to 2 (PC+4) and both memory strobes to 0.
- R6: JALR (opcode 1100111) drives operand-1 select to 0 and operand-2 select to 1, the register write strobe to 1 and the write-back select to 2, with no memory access.
- R7: A conditional branch (opcode 1100011) drives operand-1 select to 1 and operand-2 select to 1, and holds the register write strobe, both memory strobes and the write-back select at 0.
- R8: A register-register instruction (opcode 0110011) drives both operand selects to 0, the register write strobe to 1, the write-back select to 0 and both memory strobes to 0.
- R9: LUI (opcode 0110111) drives operand-1 select to 2 (constant zero) and AUIPC (opcode 0010111) drives it to 1. Both drive operand-2 select to 1, the register write strobe to 1 and the write-back select to 0.
- R10: For every instruction, rs1 equals bits [19:15], rs2 equals bits [24:20] and rd equals bits [11:7].
- R11: Any other opcode holds every strobe at 0, both selects at 0, the write-back select at 0 and the immediate at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs1_addr_o | output | 5 | First source register address |
| rs2_addr_o | output | 5 | Second source register address |
| rd_addr_o | output | 5 | Destination register address |
| imm_o | output | 32 | Sign-extended immediate |
| op1_sel_o | output | 2 | ALU operand 1: 0 rs1, 1 instruction address, 2 zero |
| op2_sel_o | output | 1 | ALU operand 2: 0 rs2, 1 immediate |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_wr_en_o | output | 1 | Memory write strobe |
| reg_wr_en_o | output | 1 | Register file write strobe |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |

## Verification
Some relations hold whatever instruction arrives, and the assertions check these on every evaluation. The memory strobes never rise together. A store never writes the register file. A memory write-back always comes with a memory read. U-class immediates have zero low bits, branch and jump offsets are even, and the zero operand path is used only with the immediate. Unknown opcodes leave every strobe low. The exact bit scattering of each immediate, the sign extension of negative offsets and the per-class select values can only be shown by the bench's scenarios. Those scenarios use hand-encoded words with known fields, including negative and bit-11 boundary offsets.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int OPC_W   = 7;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_ALUI   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_REG,
        CLS_ALUI,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_LUI,
        CLS_AUIPC,
        CLS_JAL,
        CLS_JALR
    } icls_e;

    typedef enum logic [1:0] {
        OP1_RS1  = 2'd0,
        OP1_PC   = 2'd1,
        OP1_ZERO = 2'd2
    } op1_sel_e;

    typedef enum logic {
        OP2_RS2 = 1'b0,
        OP2_IMM = 1'b1
    } op2_sel_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_MEM = 2'd1,
        WB_PC4 = 2'd2
    } wb_sel_e;

    typedef struct packed {
        op1_sel_e op1_sel;
        op2_sel_e op2_sel;
        logic     mem_rd;
        logic     mem_wr;
        logic     reg_wr;
        wb_sel_e  wb_sel;
    } ctrl_t;

endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output icls_e            cls_o
);

    always_comb begin
        unique case (opcode_i)
            OPC_REG:    cls_o = CLS_REG;
            OPC_ALUI:   cls_o = CLS_ALUI;
            OPC_LOAD:   cls_o = CLS_LOAD;
            OPC_STORE:  cls_o = CLS_STORE;
            OPC_BRANCH: cls_o = CLS_BRANCH;
            OPC_LUI:    cls_o = CLS_LUI;
            OPC_AUIPC:  cls_o = CLS_AUIPC;
            OPC_JAL:    cls_o = CLS_JAL;
            OPC_JALR:   cls_o = CLS_JALR;
            default:    cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
    import rvdec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [31:7]  bits_i,
    input  icls_e        cls_i,
    output logic [W-1:0] imm_o
);

    localparam int EXT_I = W - 12;
    localparam int EXT_B = W - 12;
    localparam int EXT_J = W - 20;
    localparam int EXT_U = W - 32;

    logic          sgn;
    logic [W-1:0]  imm_i, imm_s, imm_b, imm_u, imm_j;

    assign sgn   = bits_i[31];
    assign imm_i = {{EXT_I{sgn}}, bits_i[31:20]};
    assign imm_s = {{EXT_I{sgn}}, bits_i[31:25], bits_i[11:7]};
    assign imm_b = {{EXT_B{sgn}}, bits_i[7], bits_i[30:25], bits_i[11:8], 1'b0};
    assign imm_j = {{EXT_J{sgn}}, bits_i[19:12], bits_i[20], bits_i[30:21], 1'b0};

    generate
        if (EXT_U > 0) begin : g_u_wide
            assign imm_u = {{EXT_U{sgn}}, bits_i[31:12], 12'b0};
        end else begin : g_u_exact
            assign imm_u = {bits_i[31:12], 12'b0};
        end
    endgenerate

    always_comb begin
        unique case (cls_i)
            CLS_ALUI, CLS_LOAD, CLS_JALR: imm_o = imm_i;
            CLS_STORE:                    imm_o = imm_s;
            CLS_BRANCH:                   imm_o = imm_b;
            CLS_LUI, CLS_AUIPC:           imm_o = imm_u;
            CLS_JAL:                      imm_o = imm_j;
            default:                      imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  icls_e cls_i,
    output ctrl_t ctrl_o
);

    always_comb begin
        ctrl_o = '{op1_sel: OP1_RS1, op2_sel: OP2_RS2, mem_rd: 1'b0,
                   mem_wr: 1'b0, reg_wr: 1'b0, wb_sel: WB_ALU};
        unique case (cls_i)
            CLS_REG: begin
                ctrl_o.reg_wr = 1'b1;
            end
            CLS_ALUI: begin
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.reg_wr  = 1'b1;
            end
            CLS_LOAD: begin
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.wb_sel  = WB_MEM;
            end
            CLS_STORE: begin
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.mem_wr  = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl_o.op1_sel = OP1_PC;
                ctrl_o.op2_sel = OP2_IMM;
            end
            CLS_LUI: begin
                ctrl_o.op1_sel = OP1_ZERO;
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.reg_wr  = 1'b1;
            end
            CLS_AUIPC: begin
                ctrl_o.op1_sel = OP1_PC;
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.reg_wr  = 1'b1;
            end
            CLS_JAL: begin
                ctrl_o.op1_sel = OP1_PC;
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.wb_sel  = WB_PC4;
            end
            CLS_JALR: begin
                ctrl_o.op2_sel = OP2_IMM;
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.wb_sel  = WB_PC4;
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        assert_mem_excl_R1: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
            else $error("both memory strobes high");
    end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
(
    input  logic [31:0]       instr_i,
    output logic [REG_AW-1:0] rs1_addr_o,
    output logic [REG_AW-1:0] rs2_addr_o,
    output logic [REG_AW-1:0] rd_addr_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [1:0]        op1_sel_o,
    output logic              op2_sel_o,
    output logic              mem_rd_en_o,
    output logic              mem_wr_en_o,
    output logic              reg_wr_en_o,
    output logic [1:0]        wb_sel_o
);

    icls_e cls;
    ctrl_t ctrl;

    rvdec_class u_class (
        .opcode_i (instr_i[OPC_W-1:0]),
        .cls_o    (cls)
    );

    rvdec_imm #(.W(XLEN)) u_imm (
        .bits_i (instr_i[31:7]),
        .cls_i  (cls),
        .imm_o  (imm_o)
    );

    rvdec_ctrl u_ctrl (
        .cls_i  (cls),
        .ctrl_o (ctrl)
    );

    assign rs1_addr_o  = instr_i[19:15];
    assign rs2_addr_o  = instr_i[24:20];
    assign rd_addr_o   = instr_i[11:7];
    assign op1_sel_o   = ctrl.op1_sel;
    assign op2_sel_o   = ctrl.op2_sel;
    assign mem_rd_en_o = ctrl.mem_rd;
    assign mem_wr_en_o = ctrl.mem_wr;
    assign reg_wr_en_o = ctrl.reg_wr;
    assign wb_sel_o    = ctrl.wb_sel;

    always_comb begin
        assert_store_nowb_R2: assert (!(mem_wr_en_o && reg_wr_en_o))
            else $error("store writes register file");
        assert_memwb_read_R1: assert (!(wb_sel_o == WB_MEM) || mem_rd_en_o)
            else $error("memory write-back without read");
        assert_uimm_low_R4: assert (!(op2_sel_o && (op1_sel_o == OP1_ZERO))
                                    || (imm_o[11:0] == 12'd0))
            else $error("upper immediate has low bits set");
        assert_even_target_R4: assert (!(op1_sel_o == OP1_PC && op2_sel_o)
                                       || !imm_o[0])
            else $error("pc-relative offset is odd");
        assert_zero_needs_imm_R9: assert (!(op1_sel_o == OP1_ZERO) || op2_sel_o)
            else $error("zero operand without immediate");
        assert_none_quiet_R11: assert (cls != CLS_NONE
                                       || (imm_o == '0 && !reg_wr_en_o
                                           && !mem_rd_en_o && !mem_wr_en_o))
            else $error("unknown opcode has side effects");
    end

endmodule

// File: tb/rvdec_top_tb.sv
module rvdec_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        done = 1'b0;

    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic [1:0]  op1, wb;
    logic        op2, mrd, mwr, rwr;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [4:0]  rs1, rs2, rd;
        logic [31:0] imm;
        logic [1:0]  op1;
        logic        op2, mrd, mwr, rwr;
        logic [1:0]  wb;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    rvdec_top u_dut (
        .instr_i     (instr),
        .rs1_addr_o  (rs1),
        .rs2_addr_o  (rs2),
        .rd_addr_o   (rd),
        .imm_o       (imm),
        .op1_sel_o   (op1),
        .op2_sel_o   (op2),
        .mem_rd_en_o (mrd),
        .mem_wr_en_o (mwr),
        .reg_wr_en_o (rwr),
        .wb_sel_o    (wb)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [31:0] w, logic [4:0] e_rs1, logic [4:0] e_rs2,
                        logic [4:0] e_rd, logic [31:0] e_imm, logic [1:0] e_op1,
                        logic e_op2, logic e_mrd, logic e_mwr, logic e_rwr,
                        logic [1:0] e_wb, string req);
        @(posedge clk);
        instr <= w;
        exp_q.push_back('{rs1: e_rs1, rs2: e_rs2, rd: e_rd, imm: e_imm, op1: e_op1,
                          op2: e_op2, mrd: e_mrd, mwr: e_mwr, rwr: e_rwr, wb: e_wb});
        tag_q.push_back(req);
    endtask

    // monitor: pops one expected item per decoded word at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk("R10", "rs1", {27'd0, rs1}, {27'd0, e.rs1});
                chk("R10", "rs2", {27'd0, rs2}, {27'd0, e.rs2});
                chk("R10", "rd",  {27'd0, rd},  {27'd0, e.rd});
                chk(t == "R8" || t == "R11" ? t : "R4", "imm", imm, e.imm);
                chk(t, "op1_sel", {30'd0, op1}, {30'd0, e.op1});
                chk(t, "op2_sel", {31'd0, op2}, {31'd0, e.op2});
                chk(t, "mem_rd",  {31'd0, mrd}, {31'd0, e.mrd});
                chk(t, "mem_wr",  {31'd0, mwr}, {31'd0, e.mwr});
                chk(t, "reg_wr",  {31'd0, rwr}, {31'd0, e.rwr});
                chk(t, "wb_sel",  {30'd0, wb},  {30'd0, e.wb});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // reset state: word zero is an unknown opcode, R11
        @(negedge clk);
        chk("R11", "reset imm", imm, 32'h0);
        chk("R11", "reset strobes", {29'd0, mrd, mwr, rwr}, 32'h0);
        chk("R11", "reset selects", {27'd0, op1, op2, wb}, 32'h0);
        rst_n = 1'b1;

        send(32'hFFC10113,  2, 28,  2, 32'hFFFFFFFC, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, "R3");
        send(32'hFF832283,  6, 24,  5, 32'hFFFFFFF8, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, "R1");
        send(32'h00F62023, 12, 15,  0, 32'h00000000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        send(32'hFE952FA3, 10,  9, 31, 32'hFFFFFFFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, "R2");
        send(32'h002081B3,  1,  2,  3, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, "R8");
        send(32'h41DF0FB3, 30, 29, 31, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, "R8");
        send(32'hFE2088E3,  1,  2, 17, 32'hFFFFFFF0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
        send(32'h000010E3,  0,  0,  1, 32'h00000800, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, "R7");
        send(32'h123453B7,  8,  3,  7, 32'h12345000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, "R9");
        send(32'h80000417,  0,  0,  8, 32'h80000000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, "R9");
        send(32'h0440006F,  0,  4,  0, 32'h00000044, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, "R5");
        send(32'h801FF0EF, 31,  1,  1, 32'hFFFFF800, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, "R5");
        send(32'h00C280E7,  5, 12,  1, 32'h0000000C, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, "R6");
        send(32'h00000073,  0,  0,  0, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R11");
        send(32'hFFFFFF8B, 31, 31, 31, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R11");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule